// File: doc/BRIEF.md
# Masked Pipelined Sign Binarizer

This block decides the sign of a signed W-bit total that is held only as two arithmetic shares, and it does so without ever adding the shares together. Each share pair is captured whole on entry. A chain of registered stages then walks up the words one bit position per cycle. Each stage carries the running carry under a Boolean mask that is refreshed from a fresh random bit at every stage. The last stage turns the carry into the sign bit of the total. It emits the binarized activation, 1 for a non-negative total and 0 for a negative one, as two Boolean shares. Because the words advance through the chain together with the carry, a new share pair can be accepted on every clock.

The block has a second mode that compares two shared scores. Score A is held as shares (a0, a1) and score B as shares (b0, b1). The block forms the cross differences a0-b1 and a1-b0 and feeds them to the same chain. The shares of one score are never combined with each other. The random bits arrive on a plain input port, one bit per stage per cycle. Producing them is left to the surrounding logic.

Top module: `masked_sign_binarizer`

## Requirements
- R1: In sign mode (`cmp_mode`=0), the XOR of `act_sh0` and `act_sh1` equals the inverse of bit W-1 of (opa_sh0 + opa_sh1) mod 2^W. That is 1 for a non-negative total and 0 for a negative one.
- R2: A total of exactly zero gives activation 1.
- R3: A pair sampled with `in_valid`=1 on clock edge n produces its result, with `out_valid`=1, after edge n+W, and not at any other time. There are W+1 register stages counting the capture register.
- R4: Pairs presented on consecutive cycles each give their own correct result on consecutive cycles.
- R5: In compare mode (`cmp_mode`=1), the XOR of the output shares is 1 when A >= B and 0 otherwise. Here A = opa_sh0+opa_sh1 and B = opb_sh0+opb_sh1, and A-B must fit in W signed bits.
- R6: In a cycle where `out_valid` is 0, `act_sh0` and `act_sh1` keep the values they had in the previous cycle.
- R7: After reset, `out_valid`, `act_sh0` and `act_sh1` are all 0.
- R8: `act_sh0` of a result equals bit W-1 of `rnd_bits` as sampled on the edge that loads that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | A share pair is presented this cycle |
| cmp_mode | input | 1 | 0: sign of opa total; 1: compare score A against score B |
| opa_sh0 | input | W | First arithmetic share of the operand or of score A |
| opa_sh1 | input | W | Second arithmetic share of the operand or of score A |
| opb_sh0 | input | W | First share of score B (compare mode only) |
| opb_sh1 | input | W | Second share of score B (compare mode only) |
| rnd_bits | input | W | Fresh random bits; bit k is used by stage k in the current cycle |
| out_valid | output | 1 | A result is on the activation shares |
| act_sh0 | output | 1 | First Boolean share of the activation |
| act_sh1 | output | 1 | Second Boolean share of the activation |

## Verification
The hardest case to reach is a carry that must ripple through every stage. One example is an operand of all ones plus an operand of one, where each stage must pass a masked carry it received from the stage below. The hard variant is when such pairs arrive back to back with different random bits in every cycle. The bench reduces the width to six bits and applies every share pair in consecutive cycles, which covers every carry pattern, every zero total and every overflow boundary. It then sweeps all score pairs in compare mode. Idle gaps are inserted between vectors to observe the hold behaviour.

// File: rtl/mbin_pkg.sv
package mbin_pkg;

  typedef enum logic {
    OP_SIGN = 1'b0,
    OP_CMP  = 1'b1
  } op_mode_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/mbin_entry.sv
module mbin_entry
  import mbin_pkg::*;
#(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         cmp_mode,
  input  logic [W-1:0] a0,
  input  logic [W-1:0] a1,
  input  logic [W-1:0] b0,
  input  logic [W-1:0] b1,
  output logic         v_q,
  output logic [W-1:0] s0_q,
  output logic [W-1:0] s1_q
);

  logic [W-1:0] s0_d, s1_d;
  op_mode_e     mode;

  always_comb begin
    mode = op_mode_e'(cmp_mode);
    if (mode == OP_CMP) begin
      s0_d = a0 - b1;
      s1_d = a1 - b0;
    end else begin
      s0_d = a0;
      s1_d = a1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      s0_q <= '0;
      s1_q <= '0;
    end else begin
      v_q <= in_valid;
      if (in_valid) begin
        s0_q <= s0_d;
        s1_q <= s1_d;
      end
    end
  end

  logic [W-1:0] cap_total, chk_sum, chk_diff;
  assign cap_total = s0_q + s1_q;
  assign chk_sum   = a0 + a1;
  assign chk_diff  = a0 + a1 - b0 - b1;

  assert_capture_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cmp_mode) |=> (cap_total == $past(chk_sum)));

  assert_capture_diff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cmp_mode) |=> (cap_total == $past(chk_diff)));

endmodule

// File: rtl/mbin_carry_stage.sv
module mbin_carry_stage
  import mbin_pkg::*;
#(
  parameter int   IW    = 19,
  parameter logic FIRST = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v_i,
  input  logic          mc_i,
  input  logic          m_i,
  input  logic [IW-1:0] a_i,
  input  logic [IW-1:0] b_i,
  input  logic          r_i,
  output logic          v_o,
  output logic          mc_o,
  output logic          m_o,
  output logic [IW-2:0] a_o,
  output logic [IW-2:0] b_o
);

  logic          c_in, mc_d, m_d;
  logic [IW-2:0] a_d, b_d;

  always_comb begin
    c_in = FIRST ? 1'b0 : (mc_i ^ m_i);
    mc_d = maj3(a_i[0], b_i[0], c_in) ^ r_i;
    m_d  = r_i;
    a_d  = a_i[IW-1:1];
    b_d  = b_i[IW-1:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o  <= 1'b0;
      mc_o <= 1'b0;
      m_o  <= 1'b0;
      a_o  <= '0;
      b_o  <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        mc_o <= mc_d;
        m_o  <= m_d;
        a_o  <= a_d;
        b_o  <= b_d;
      end
    end
  end

  assert_carry_gen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (v_i && a_i[0] && b_i[0]) |=> (mc_o ^ m_o));

  assert_carry_kill_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (v_i && !a_i[0] && !b_i[0]) |=> !(mc_o ^ m_o));

endmodule

// File: rtl/mbin_sign_out.sv
module mbin_sign_out (
  input  logic clk,
  input  logic rst_n,
  input  logic v_i,
  input  logic mc_i,
  input  logic m_i,
  input  logic a_i,
  input  logic b_i,
  input  logic r_i,
  output logic v_o,
  output logic sh0_o,
  output logic sh1_o
);

  logic sh0_d, sh1_d;

  always_comb begin
    sh0_d = r_i;
    sh1_d = ((mc_i ^ r_i) ^ m_i) ^ ~(a_i ^ b_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o   <= 1'b0;
      sh0_o <= 1'b0;
      sh1_o <= 1'b0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        sh0_o <= sh0_d;
        sh1_o <= sh1_d;
      end
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !v_i |=> ($stable(sh0_o) && $stable(sh1_o)));

endmodule

// File: rtl/masked_sign_binarizer.sv
module masked_sign_binarizer
  import mbin_pkg::*;
#(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         cmp_mode,
  input  logic [W-1:0] opa_sh0,
  input  logic [W-1:0] opa_sh1,
  input  logic [W-1:0] opb_sh0,
  input  logic [W-1:0] opb_sh1,
  input  logic [W-1:0] rnd_bits,
  output logic         out_valid,
  output logic         act_sh0,
  output logic         act_sh1
);

  localparam int CHAIN = W - 1;
  localparam int CW    = $clog2(W + 2) + 1;
  localparam logic [CW-1:0] IDLE_MAX = CW'(W + 1);

  logic         ent_v;
  logic [W-1:0] ent_s0, ent_s1;

  mbin_entry #(.W(W)) u_entry (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .cmp_mode (cmp_mode),
    .a0       (opa_sh0),
    .a1       (opa_sh1),
    .b0       (opb_sh0),
    .b1       (opb_sh1),
    .v_q      (ent_v),
    .s0_q     (ent_s0),
    .s1_q     (ent_s1)
  );

  for (genvar k = 0; k < CHAIN; k++) begin : g_chain
    localparam int IW = W - k;
    logic          v_in, mc_in, m_in;
    logic [IW-1:0] a_in, b_in;
    logic          v_q, mc_q, m_q;
    logic [IW-2:0] a_q, b_q;

    if (k == 0) begin : g_head
      assign v_in  = ent_v;
      assign mc_in = 1'b0;
      assign m_in  = 1'b0;
      assign a_in  = ent_s0;
      assign b_in  = ent_s1;
    end else begin : g_link
      assign v_in  = g_chain[k-1].v_q;
      assign mc_in = g_chain[k-1].mc_q;
      assign m_in  = g_chain[k-1].m_q;
      assign a_in  = g_chain[k-1].a_q;
      assign b_in  = g_chain[k-1].b_q;
    end

    mbin_carry_stage #(.IW(IW), .FIRST(k == 0)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .v_i   (v_in),
      .mc_i  (mc_in),
      .m_i   (m_in),
      .a_i   (a_in),
      .b_i   (b_in),
      .r_i   (rnd_bits[k]),
      .v_o   (v_q),
      .mc_o  (mc_q),
      .m_o   (m_q),
      .a_o   (a_q),
      .b_o   (b_q)
    );
  end

  mbin_sign_out u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .v_i   (g_chain[CHAIN-1].v_q),
    .mc_i  (g_chain[CHAIN-1].mc_q),
    .m_i   (g_chain[CHAIN-1].m_q),
    .a_i   (g_chain[CHAIN-1].a_q[0]),
    .b_i   (g_chain[CHAIN-1].b_q[0]),
    .r_i   (rnd_bits[W-1]),
    .v_o   (out_valid),
    .sh0_o (act_sh0),
    .sh1_o (act_sh1)
  );

  logic [CW-1:0] idle_cnt, idle_cnt_d;

  always_comb begin
    if (in_valid)              idle_cnt_d = '0;
    else if (idle_cnt < IDLE_MAX) idle_cnt_d = idle_cnt + 1'b1;
    else                       idle_cnt_d = idle_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_cnt <= IDLE_MAX;
    else        idle_cnt <= idle_cnt_d;
  end

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt == IDLE_MAX) |-> !out_valid);

endmodule

// File: tb/masked_sign_binarizer_bench.sv
module masked_sign_binarizer_bench;

  localparam int BW     = 6;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 8192;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, cmp_mode;
  logic [BW-1:0] opa_sh0, opa_sh1, opb_sh0, opb_sh1, rnd_bits;
  logic out_valid, act_sh0, act_sh1;

  always #(CLK_NS/2) clk = ~clk;

  masked_sign_binarizer #(.W(BW)) u_masked_sign_binarizer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cmp_mode(cmp_mode),
    .opa_sh0(opa_sh0), .opa_sh1(opa_sh1), .opb_sh0(opb_sh0), .opb_sh1(opb_sh1),
    .rnd_bits(rnd_bits), .out_valid(out_valid), .act_sh0(act_sh0), .act_sh1(act_sh1)
  );

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit exp_v   [DEPTH];
  bit exp_act [DEPTH];
  int exp_tag [DEPTH];
  logic [BW-1:0] rnd_hist [DEPTH];
  logic prev0, prev1;
  bit armed = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
    end
  endtask

  task automatic check_out();
    int e;
    string tg;
    if (!armed) return;
    e = cyc - BW;
    if (e >= 0 && e < DEPTH && exp_v[e]) begin
      tg = (exp_tag[e] == 5) ? "R5" : (exp_tag[e] == 2) ? "R2" : "R1/R4";
      chk(out_valid == 1'b1, "R3", out_valid, 1);
      chk((act_sh0 ^ act_sh1) == exp_act[e], tg, act_sh0 ^ act_sh1, exp_act[e]);
      chk(act_sh0 == rnd_hist[cyc][BW-1], "R8", act_sh0, rnd_hist[cyc][BW-1]);
    end else begin
      chk(out_valid == 1'b0, "R3", out_valid, 0);
      chk(act_sh0 == prev0 && act_sh1 == prev1, "R6",
          {act_sh0, act_sh1}, {prev0, prev1});
    end
    prev0 = act_sh0;
    prev1 = act_sh1;
  endtask

  task automatic issue(input bit v, input bit m, input bit act, input int tag,
                       input logic [BW-1:0] p0, input logic [BW-1:0] p1,
                       input logic [BW-1:0] q0, input logic [BW-1:0] q1);
    int idx;
    @(negedge clk);
    check_out();
    in_valid = v; cmp_mode = m;
    opa_sh0 = p0; opa_sh1 = p1; opb_sh0 = q0; opb_sh1 = q1;
    rnd_bits = BW'($urandom);
    idx = cyc + 1;
    if (idx < DEPTH) begin
      exp_v[idx] = v; exp_act[idx] = act; exp_tag[idx] = tag;
      rnd_hist[idx] = rnd_bits;
    end
  endtask

  task automatic idle();
    issue(1'b0, 1'b0, 1'b0, 0, BW'($urandom), BW'($urandom), BW'($urandom), BW'($urandom));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [BW-1:0] tot, s0;
    rst_n = 1'b0; in_valid = 1'b0; cmp_mode = 1'b0;
    opa_sh0 = '0; opa_sh1 = '0; opb_sh0 = '0; opb_sh1 = '0; rnd_bits = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R7: reset state
    chk(out_valid == 1'b0, "R7", out_valid, 0);
    chk(act_sh0 == 1'b0 && act_sh1 == 1'b0, "R7", {act_sh0, act_sh1}, 0);
    prev0 = 1'b0; prev1 = 1'b0;
    armed = 1;

    // R1, R2, R4: every share pair back to back in sign mode
    for (int i = 0; i < (1 << BW); i++) begin
      for (int j = 0; j < (1 << BW); j++) begin
        tot = BW'(i + j);
        issue(1'b1, 1'b0, ~tot[BW-1], (tot == 0) ? 2 : 1, BW'(i), BW'(j),
              BW'($urandom), BW'($urandom));
      end
    end

    // R3, R6: isolated vectors separated by idle gaps
    for (int g = 0; g < 12; g++) begin
      s0 = BW'($urandom);
      tot = BW'(g * 5 - 30);
      issue(1'b1, 1'b0, ~tot[BW-1], (tot == 0) ? 2 : 1, s0, tot - s0, '0, '0);
      for (int d = 0; d < g % 4 + BW; d++) idle();
    end

    // R5: every score pair in compare mode with random share splits
    for (int a = -(1 << (BW-2)); a < (1 << (BW-2)); a++) begin
      for (int b = -(1 << (BW-2)); b < (1 << (BW-2)); b++) begin
        logic [BW-1:0] ra, rb;
        ra = BW'($urandom);
        rb = BW'($urandom);
        issue(1'b1, 1'b1, (a >= b), 5, ra, BW'(a) - ra, rb, BW'(b) - rb);
      end
    end

    for (int d = 0; d < BW + 3; d++) idle();

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule